// File: doc/BRIEF.md
# Timer Burst Register Sequencer

This block sits in front of a small timer register file. It turns a run of accesses to one fixed address into accesses to consecutive registers. A control register holds two 5-bit fields: a start offset and a transfer-count code. Each read or write that hits the burst port is sent to the register at the start offset plus a running index. The index moves forward by one on every such access. It returns to zero once the programmed number of transfers has been made, so a streaming agent can refill a window of timer registers again and again through a single address.

Every register in the file can also be reached at its own address, which lets software or a test agent inspect the result of a burst. Each burst access carries a size select. In half-word mode all 16 bits move. In byte mode only the low byte moves, and the upper byte of the register is zero-filled. A target that falls past the last register is dropped on writes and reads back as zero, and it still consumes its slot in the burst.

Top module: `tbs_seq`

## Requirements
- R1: After reset the control register reads 0x0000, the burst index is zero, and every file register reads 0x0000.
- R2: The control register sits at address 32. Bits 12:8 hold the count code and bits 4:0 hold the start offset. Bits 15:13 and 7:5 always read as zero, whatever was written to them.
- R3: Addresses 0 to 31 read and write file registers directly with all 16 bits. The burst port sits at address 33, and an access there targets register (start offset + index).
- R4: Every burst access advances the index by one, whether it is a read, a write or both in the same cycle. After code+1 accesses the index returns to zero.
- R5: Any count code above 17 gives 18 transfers per burst.
- R6: A write to the control register sets the index to zero.
- R7: A burst write with the size select at 1 (byte) stores {8'h00, wdata[7:0]}. A burst read with the size select at 1 returns {8'h00, reg[7:0]}. With the size select at 0, all 16 bits move.
- R8: When start offset + index is greater than 31, a burst write changes no register and a burst read returns zero. The index still advances.
- R9: Addresses 34 to 63 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_byte | input | 1 | Burst size select: 1 = byte, 0 = half-word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address, combinational |

## Verification
The index wrap and the register update of the final transfer happen in the same clock edge. A burst with a 1-transfer code wraps on every access, so with that code each write must still land in the start register. Back-to-back bursts of clamped and out-of-range lengths are interleaved with control rewrites and with cycles that read and write at once. Each access is judged against a bench model of the index, and the file contents are read back directly.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  // Control register fields; widths fixed by the register layout
  typedef struct packed {
    logic [4:0] len_code;
    logic [4:0] base;
  } tbs_ctrl_t;
endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
  import tbs_pkg::*;
#(
  parameter int MAX_XFER = 18,
  parameter int IDX_W    = 5,
  parameter int DW       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [DW-1:0]    wdata,
  input  logic             step,
  output tbs_ctrl_t        ctrl,
  output logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    ctrl_word
);
  localparam int LEN_W = 6;

  tbs_ctrl_t        ctrl_nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic [LEN_W-1:0] len_eff;
  logic             last;

  always_comb begin
    if (ctrl.len_code >= 5'(MAX_XFER - 1)) len_eff = LEN_W'(MAX_XFER);
    else                                   len_eff = {1'b0, ctrl.len_code} + 6'd1;
    last = (LEN_W'(idx) == len_eff - 6'd1);
  end

  always_comb begin
    ctrl_nxt = ctrl;
    idx_nxt  = idx;
    if (ctrl_we) begin
      ctrl_nxt.len_code = wdata[12:8];
      ctrl_nxt.base     = wdata[4:0];
      idx_nxt           = '0;
    end else if (step) begin
      idx_nxt = last ? '0 : idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      idx  <= '0;
    end else if (ctrl_we || step) begin
      ctrl <= ctrl_nxt;
      idx  <= idx_nxt;
    end
  end

  assign ctrl_word = DW'({3'b000, ctrl.len_code, 3'b000, ctrl.base});

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctrl_we && !last) |=> idx == $past(idx) + IDX_W'(1));

  // R6
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> idx == '0);

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IDX_W'(MAX_XFER));
endmodule

// File: rtl/tbs_regfile.sv
module tbs_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 16,
  parameter int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [NREG-1:0][DW-1:0] mem;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (addr == RA_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[g] <= '0;
      else if (en) mem[g] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R8
  regfile_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/tbs_seq.sv
module tbs_seq
  import tbs_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int DW       = 16,
  parameter int AW       = 6,
  parameter int MAX_XFER = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_byte,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int RA_W       = $clog2(NREG);
  localparam int IDX_W      = $clog2(MAX_XFER);
  localparam int TW         = 7;
  localparam int CTRL_ADDR  = NREG;
  localparam int BURST_ADDR = NREG + 1;

  tbs_ctrl_t        ctrl;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    ctrl_word;
  logic             hit_dir, hit_ctrl, hit_burst;
  logic [TW-1:0]    tgt;
  logic             tgt_ok;
  logic             rf_we;
  logic [RA_W-1:0]  rf_addr;
  logic [DW-1:0]    rf_wdata, rf_rdata;

  always_comb begin
    hit_dir   = bus_addr < AW'(NREG);
    hit_ctrl  = bus_addr == AW'(CTRL_ADDR);
    hit_burst = bus_addr == AW'(BURST_ADDR);
    tgt       = TW'(ctrl.base) + TW'(idx);
    tgt_ok    = tgt < TW'(NREG);
    rf_we     = bus_wr && (hit_dir || (hit_burst && tgt_ok));
    rf_addr   = hit_burst ? tgt[RA_W-1:0] : bus_addr[RA_W-1:0];
    rf_wdata  = (hit_burst && bus_byte) ? {{(DW-8){1'b0}}, bus_wdata[7:0]} : bus_wdata;
    if (hit_dir)
      bus_rdata = rf_rdata;
    else if (hit_ctrl)
      bus_rdata = ctrl_word;
    else if (hit_burst && tgt_ok)
      bus_rdata = bus_byte ? {{(DW-8){1'b0}}, rf_rdata[7:0]} : rf_rdata;
    else
      bus_rdata = '0;
  end

  tbs_ctrl #(.MAX_XFER(MAX_XFER), .IDX_W(IDX_W), .DW(DW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (bus_wr && hit_ctrl),
    .wdata     (bus_wdata),
    .step      ((bus_rd || bus_wr) && hit_burst),
    .ctrl      (ctrl),
    .idx       (idx),
    .ctrl_word (ctrl_word)
  );

  tbs_regfile #(.NREG(NREG), .DW(DW), .RA_W(RA_W)) i_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .addr  (rf_addr),
    .wdata (rf_wdata),
    .rdata (rf_rdata)
  );

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |-> (bus_rdata[15:13] == 3'b000 && bus_rdata[7:5] == 3'b000));

  // R9
  high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > AW'(BURST_ADDR)) |-> bus_rdata == '0);
endmodule

// File: tb/test_tbs_seq.sv
`timescale 1ns/1ps
module test_tbs_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr, bus_rd, bus_byte;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model, built from the requirements
  logic [15:0] m_reg [32];
  int m_len, m_base, m_idx;

  always #2.5 clk = ~clk;

  tbs_seq i_tbs_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] m_read(int a, bit byt);
    int t;
    if (a < 32) return m_reg[a];
    if (a == 32) return 16'({3'b0, 5'(m_len), 3'b0, 5'(m_base)});
    if (a == 33) begin
      t = m_base + m_idx;
      if (t > 31) return 16'h0;
      return byt ? {8'h00, m_reg[t][7:0]} : m_reg[t];
    end
    return 16'h0;
  endfunction

  function automatic void m_update(int a, bit wr, bit rd, bit byt, logic [15:0] d);
    int t, n;
    if (wr && a < 32) m_reg[a] = d;
    if (wr && a == 32) begin
      m_len = int'(d[12:8]); m_base = int'(d[4:0]); m_idx = 0;
    end
    if (a == 33 && (wr || rd)) begin
      t = m_base + m_idx;
      if (wr && t <= 31) m_reg[t] = byt ? {8'h00, d[7:0]} : d;
      n = (m_len > 17) ? 18 : m_len + 1;
      m_idx = (m_idx == n - 1) ? 0 : m_idx + 1;
    end
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, int a, bit wr, bit rd, bit byt, logic [15:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_wr = wr; bus_rd = rd; bus_byte = byt; bus_wdata = d;
    #1;
    if (rd) chk(tag, bus_rdata, m_read(a, byt));
    m_update(a, wr, rd, byt, d);
    @(posedge clk);
  endtask

  function automatic string burst_tag(bit byt);
    if (m_base + m_idx > 31) return "R8";
    return byt ? "R7" : "R4";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r, a;
    logic [15:0] d;
    void'($urandom(32'd7741));
    for (int i = 0; i < 32; i++) m_reg[i] = 16'h0;
    m_len = 0; m_base = 0; m_idx = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_byte = 0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    op("R1", 32, 0, 1, 0, 0);
    op("R1", 5, 0, 1, 0, 0);
    op("R1", 33, 0, 1, 0, 0);
    // R2 reserved bits read zero
    op("R2", 32, 1, 0, 0, 16'hFFFF);
    op("R2", 32, 0, 1, 0, 0);
    // R6 control write clears index
    op("R6", 32, 1, 0, 0, 16'h0304);
    op("R6", 33, 1, 0, 0, 16'hAAAA);
    op("R6", 33, 1, 0, 0, 16'hBBBB);
    op("R6", 32, 1, 0, 0, 16'h0304);
    op("R6", 33, 1, 0, 0, 16'hCCCC);
    op("R6", 4, 0, 1, 0, 0);
    op("R6", 5, 0, 1, 0, 0);
    // R5 clamp: code 31 gives 18 transfers, 19th write wraps to start
    op("R5", 32, 1, 0, 0, 16'h1F00);
    for (int k = 0; k < 19; k++) op("R5", 33, 1, 0, 0, 16'(16'h0100 + k));
    op("R5", 0, 0, 1, 0, 0);
    op("R5", 17, 0, 1, 0, 0);
    op("R5", 18, 0, 1, 0, 0);
    // R4 one-transfer code wraps every access; read+write same cycle
    op("R4", 32, 1, 0, 0, 16'h0009);
    op("R4", 33, 1, 1, 0, 16'h1234);
    op("R4", 33, 1, 1, 0, 16'h5678);
    op("R4", 9, 0, 1, 0, 0);
    // R8 out-of-range tail
    op("R8", 32, 1, 0, 0, 16'h031E);
    for (int k = 0; k < 5; k++) op("R8", 33, 1, 0, 0, 16'(16'hE000 + k));
    op("R8", 30, 0, 1, 0, 0);
    op("R8", 31, 0, 1, 0, 0);
    op("R8", 33, 0, 1, 0, 0);
    op("R8", 33, 0, 1, 0, 0);
    op("R8", 33, 0, 1, 0, 0);
    // R7 byte mode
    op("R7", 32, 1, 0, 0, 16'h0102);
    op("R7", 33, 1, 0, 1, 16'hABCD);
    op("R7", 33, 1, 0, 0, 16'hABCD);
    op("R7", 2, 0, 1, 0, 0);
    op("R7", 3, 0, 1, 0, 0);
    op("R7", 33, 0, 1, 1, 0);
    // R9 high addresses
    op("R9", 40, 1, 0, 0, 16'hFFFF);
    op("R9", 40, 0, 1, 0, 0);
    op("R9", 63, 0, 1, 0, 0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      r = $urandom % 16;
      d = 16'($urandom);
      if (r < 2) begin
        op("R6", 32, 1, 0, 0, d);
      end else if (r < 5) begin
        a = $urandom % 32;
        op("R3", a, 1'($urandom), 1'($urandom), 0, d);
      end else if (r < 6) begin
        a = 34 + ($urandom % 30);
        op("R9", a, 1'($urandom), 1'($urandom), 0, d);
      end else begin
        bit w, rr, b;
        w = 1'($urandom); rr = 1'($urandom); b = 1'($urandom);
        op(burst_tag(b), 33, w, rr, b, d);
      end
    end

    // R3 direct dump of the whole file
    for (int k = 0; k < 32; k++) op("R3", k, 0, 1, 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule